// File: doc/BRIEF.md
# Per-Processor Interval Timer Bank

This block holds a row of identical down-counting event timers, one per processor, all reached through a single register port. Each timer occupies an 8-byte window. Its first word arms the timer: software writes a 29-bit count with an enable flag and a repeat flag. The second word reports the live count and a pending flag, and a write with the clear bit set drops that flag. All timers share one timebase tick input and count down only on that tick.

A timer loaded with N expires on the (N+1)th tick it sees while enabled. On expiry it latches a level-high interrupt. In repeat mode the timer then reloads the programmed count and keeps running. In single-shot mode it turns itself off. Writing zero to the arming word stops the timer. Writing the arming word while the timer runs restarts the count from the new value.

Top module: `evt_timer_bank`

## Requirements
- R1: While reset is held, and after it is released, every irq bit is 0 and both words of every timer read as 0.
- R2: A write to the arming word (offset 0x0 of a window) takes bit 31 as enable, bit 30 as repeat (1) or single-shot (0), and bits 28:0 as the count. Reading that word returns {enable, repeat, 0, programmed count}.
- R3: A timer armed with count N raises its irq after exactly N+1 enabled ticks. The irq bit goes high in the cycle after the clock edge that samples the final tick, and never in a cycle whose previous edge had no tick.
- R4: In single-shot mode the enable bit reads 0 after expiry and the count stays at 0. No further interrupt follows once the pending flag is cleared.
- R5: In repeat mode the timer reloads the programmed count on the expiring tick, keeps its enable bit, and expires again every N+1 ticks.
- R6: A write to the status word (offset 0x4) with bit 30 set clears the pending flag and the irq in the next cycle. A write with bit 30 clear has no effect. If an expiry happens on the same edge as a clear, the expiry wins.
- R7: Reading the status word returns the pending flag in bit 31 and the current count in bits 28:0, with all other bits 0.
- R8: Writing 0 to the arming word stops the timer: further ticks neither change the count nor raise the irq.
- R9: Rewriting the arming word while the timer runs restarts the count from the new value, so the next expiry comes N+1 ticks after that write.
- R10: Timer k sits at byte address 8*k. Accesses whose low two address bits are not zero are ignored and read 0. So are accesses at or beyond 8*NUM_TMR. A write reaches only the addressed timer.
- R11: With no tick, the count and the irq of an enabled timer hold.
- R12: Read data and rd_vld appear in the cycle after rd_en. rd_vld is high for exactly that one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Shared timebase tick, one-cycle pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_vld | output | 1 | Read data valid |
| irq_o | output | NUM_TMR | Level-high interrupt per timer |

## Verification
Every write and every tick takes effect on the edge that samples it. An irq or count therefore becomes visible one cycle after the strobe, and the expiry shows one cycle after the (N+1)th tick. Read data arrives exactly one cycle after rd_en. The driver pushes each expected read word into a queue as it issues the read, and a monitor pops it when rd_vld is seen. The driver then confirms the queue was drained on that cycle. All inputs are driven and all outputs sampled on the falling clock edge, so each check lands a half cycle after the edge that produced its result.

// File: rtl/evt_timer_pkg.sv
// Shared constants for the interval timer bank: register layout and field positions.
// Assumes 32-bit registers and a fixed 8-byte window per timer.
package evt_timer_pkg;
    localparam int TMR_CNT_W   = 29;   // width of the count field
    localparam int WIN_LG2     = 3;    // log2 of the per-timer window in bytes
    localparam int ARM_EN_BIT  = 31;   // enable flag in the arming word
    localparam int ARM_REP_BIT = 30;   // repeat flag in the arming word
    localparam int ST_CLR_BIT  = 30;   // write-one-to-clear bit in the status word
    localparam int ST_PEND_BIT = 31;   // pending flag in the status word
endpackage

// File: rtl/evt_timer_regdec.sv
// Address decoder: turns the byte address and strobes into per-timer write enables
// and a read selection. Assumes word-aligned access; anything else is a miss.
module evt_timer_regdec #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8,
    localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TMR-1:0] arm_we,
    output logic [NUM_TMR-1:0] st_we,
    output logic               hit,
    output logic               is_stat,
    output logic [SEL_W-1:0]   sel
);
    import evt_timer_pkg::*;
    localparam int IDX_W = ADDR_W - WIN_LG2;

    logic [IDX_W-1:0] idx;

    // Split the address into window index, word select and alignment check.
    always_comb begin
        idx     = addr[ADDR_W-1:WIN_LG2];
        is_stat = addr[2];
        hit     = (addr[1:0] == 2'b00) && ({1'b0, idx} < (IDX_W+1)'(NUM_TMR));
        sel     = idx[SEL_W-1:0];
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_we
        // Per-timer write enables for the two words.
        assign arm_we[i] = wr_en && hit && !is_stat && (idx == IDX_W'(i));
        assign st_we[i]  = wr_en && hit &&  is_stat && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/evt_timer_core.sv
// One down-counting timer: arming, n+1 countdown on the shared tick, reload or
// self-disable on expiry, and a sticky pending flag driving the level interrupt.
// Assumes the tick is a single-cycle pulse in the clk domain.
module evt_timer_core (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        arm_we,
    input  logic        arm_en,
    input  logic        arm_rep,
    input  logic [28:0] arm_cnt,
    input  logic        st_we,
    input  logic        clr_bit,
    output logic        irq,
    output logic [31:0] arm_view,
    output logic [31:0] st_view
);
    import evt_timer_pkg::*;

    logic                 en_q, rep_q, pend_q;
    logic [TMR_CNT_W-1:0] rld_q, cnt_q;
    logic                 expire;

    // Expiry: an enabled tick with the count already at zero, not overridden by a load.
    assign expire = tick_i && en_q && (cnt_q == '0) && !arm_we;

    // Configuration and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            rep_q <= 1'b0;
            rld_q <= '0;
            cnt_q <= '0;
        end else if (arm_we) begin
            en_q  <= arm_en;
            rep_q <= arm_rep;
            rld_q <= arm_cnt;
            cnt_q <= arm_cnt;
        end else if (expire) begin
            if (rep_q) cnt_q <= rld_q;
            else       en_q  <= 1'b0;
        end else if (tick_i && en_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pending flag: set on expiry (wins over clear), cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (expire)           pend_q <= 1'b1;
        else if (st_we && clr_bit) pend_q <= 1'b0;
    end

    assign irq      = pend_q;
    assign arm_view = {en_q, rep_q, 1'b0, rld_q};
    assign st_view  = {pend_q, 2'b00, cnt_q};
endmodule

// File: rtl/evt_timer_rdmux.sv
// Registered read path: picks one timer's word, or zero on a miss.
// Assumes sel is only meaningful when hit is set.
module evt_timer_rdmux #(
    parameter int NUM_TMR = 4,
    localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic                    hit,
    input  logic                    is_stat,
    input  logic [SEL_W-1:0]        sel,
    input  logic [NUM_TMR-1:0][31:0] arm_views,
    input  logic [NUM_TMR-1:0][31:0] st_views,
    output logic [31:0]             rdata,
    output logic                    rd_vld
);
    // Capture the selected word one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en)
                rdata <= !hit ? 32'h0 : (is_stat ? st_views[sel] : arm_views[sel]);
        end
    end
endmodule

// File: rtl/evt_timer_bank.sv
// Top of the per-processor timer bank: decoder, NUM_TMR timer cores and the read mux.
// Assumes a single-cycle register port with no wait states.
module evt_timer_bank #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               rd_vld,
    output logic [NUM_TMR-1:0] irq_o
);
    import evt_timer_pkg::*;
    localparam int SEL_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic [NUM_TMR-1:0]       arm_we, st_we;
    logic                     hit, is_stat;
    logic [SEL_W-1:0]         sel;
    logic [NUM_TMR-1:0][31:0] arm_views, st_views;
    logic                     unused_rsvd;

    assign unused_rsvd = wdata[29];

    evt_timer_regdec #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .addr(addr), .arm_we(arm_we), .st_we(st_we),
        .hit(hit), .is_stat(is_stat), .sel(sel)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        evt_timer_core u_core (
            .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
            .arm_we(arm_we[i]), .arm_en(wdata[ARM_EN_BIT]), .arm_rep(wdata[ARM_REP_BIT]),
            .arm_cnt(wdata[TMR_CNT_W-1:0]),
            .st_we(st_we[i]), .clr_bit(wdata[ST_CLR_BIT]),
            .irq(irq_o[i]), .arm_view(arm_views[i]), .st_view(st_views[i])
        );
    end

    evt_timer_rdmux #(.NUM_TMR(NUM_TMR)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit), .is_stat(is_stat),
        .sel(sel), .arm_views(arm_views), .st_views(st_views),
        .rdata(rdata), .rd_vld(rd_vld)
    );
endmodule

// File: rtl/evt_timer_chk.sv
// Protocol checker for evt_timer_bank, attached by bind below.
module evt_timer_chk #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        wdata,
    input logic               rd_vld,
    input logic [NUM_TMR-1:0] irq_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (irq_o == '0 && !rd_vld));

    // R12
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);

    // R11
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en) |=> $stable(irq_o));

    // R10
    miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick_i && addr >= ADDR_W'(8*NUM_TMR)) |=> $stable(irq_o));

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_k
        // R6
        clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !tick_i && addr == ADDR_W'(8*k+4) && wdata[30]) |=> !irq_o[k]);
        // R3
        rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[k]) |-> $past(tick_i));
    end
endmodule

bind evt_timer_bank evt_timer_chk #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_vld(rd_vld), .irq_o(irq_o)
);

// File: tb/tb_evt_timer_bank.sv
module tb_evt_timer_bank;
    localparam int NT = 4;
    localparam int AW = 8;

    logic clk = 0, rst_n = 0, tick_i = 0, wr_en = 0, rd_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic rd_vld;
    logic [NT-1:0] irq_o;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    evt_timer_bank #(.NUM_TMR(NT), .ADDR_W(AW)) dut (.*);

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pop the expected word whenever read data is valid.
    always @(negedge clk) begin
        if (rd_vld) begin
            if (exp_q.size() == 0) chk(1, 0, "R12 unexpected rd_vld");
            else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    // Driver: issue a read and push the expected word.
    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        rd_en = 1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 0;
        #1;
        chk(32'(exp_q.size()), 0, "R12 read not returned next cycle");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1;
            @(negedge clk);
        end
        tick_i = 0;
    endtask

    task automatic irq_is(input int k, input logic e, input string tag);
        chk(32'(irq_o[k]), 32'(e), tag);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(32'(irq_o), 0, "R1 irq in reset");
        rst_n = 1;
        @(negedge clk);
        chk(32'(irq_o), 0, "R1 irq after reset");
        rd(8'h00, 0, "R1 arm word");
        rd(8'h04, 0, "R1 status word");

        // R2, R7: arm timer 1 single-shot with 5
        wr(8'h08, 32'h8000_0005);
        rd(8'h08, 32'h8000_0005, "R2 arm readback");
        rd(8'h0C, 32'h0000_0005, "R7 status count");
        // R3: 5 ticks not yet, 6th expires
        ticks(5);
        irq_is(1, 0, "R3 early");
        rd(8'h0C, 32'h0000_0000, "R7 count zero");
        ticks(1);
        irq_is(1, 1, "R3 expiry at N+1");
        rd(8'h08, 32'h0000_0005, "R4 enable cleared");
        rd(8'h0C, 32'h8000_0000, "R7 pending flag");
        // R6
        wr(8'h0C, 32'h0000_0000);
        irq_is(1, 1, "R6 write without clear bit");
        wr(8'h0C, 32'h4000_0000);
        irq_is(1, 0, "R6 clear");
        ticks(10);
        irq_is(1, 0, "R4 no re-fire");

        // R5: timer 2 repeat with 3
        wr(8'h10, 32'hC000_0003);
        ticks(4);
        irq_is(2, 1, "R5 first expiry");
        rd(8'h14, 32'h8000_0003, "R5 reloaded count");
        wr(8'h14, 32'h4000_0000);
        ticks(3);
        irq_is(2, 0, "R5 before second expiry");
        ticks(1);
        irq_is(2, 1, "R5 second expiry");
        rd(8'h10, 32'hC000_0003, "R5 enable kept");

        // R8: stop timer 0 mid-count
        wr(8'h00, 32'h8000_0002);
        ticks(1);
        wr(8'h00, 32'h0);
        ticks(5);
        irq_is(0, 0, "R8 stopped");
        rd(8'h04, 32'h0, "R8 count frozen");

        // R9: restart timer 3
        wr(8'h18, 32'h8000_0004);
        ticks(3);
        wr(8'h18, 32'h8000_0004);
        ticks(4);
        irq_is(3, 0, "R9 restart delays expiry");
        ticks(1);
        irq_is(3, 1, "R9 expiry after restart");

        // R10: misses
        wr(8'h20, 32'h8000_0000);
        wr(8'h01, 32'h8000_0007);
        rd(8'h20, 32'h0, "R10 beyond last window");
        rd(8'h09, 32'h0, "R10 unaligned read");
        rd(8'h00, 32'h0, "R10 timer0 untouched");
        irq_is(1, 0, "R10 neighbour irq");

        // R11: no ticks, no change
        wr(8'h00, 32'h8000_0001);
        repeat (10) @(negedge clk);
        irq_is(0, 0, "R11 idle irq");
        rd(8'h04, 32'h0000_0001, "R11 idle count");

        // R6: expiry and clear on the same edge, expiry wins
        ticks(1);
        wr_en = 1; addr = 8'h04; wdata = 32'h4000_0000; tick_i = 1;
        @(negedge clk);
        wr_en = 0; wdata = '0; tick_i = 0;
        irq_is(0, 1, "R6 set wins over clear");
        wr(8'h04, 32'h4000_0000);
        irq_is(0, 0, "R6 clear after");

        @(negedge clk);
        chk(32'(exp_q.size()), 0, "R12 queue drained");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule